// File: doc/BRIEF.md
# Byte-Port Multiply and Divide Unit

A small arithmetic peripheral that a processor drives through a byte-wide register port. One operand register holds a multiplicand; writing a multiplier byte launches an unsigned shift-add multiply that produces a double-width product. A double-width dividend is assembled from two byte writes, and writing a divisor byte launches an unsigned restoring divide. The quotient has a register of its own. The product and the remainder share a second result register, and whichever operation was started last owns it.

Both engines are sequential. The multiply needs one cycle per multiplier bit and the divide one cycle per dividend bit. While an operation runs, a busy output is high and reads return the partially built values. Any start write cancels the operation in progress and begins the new one. A divisor of zero completes at once: the quotient becomes all ones and the remainder register takes the whole dividend.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, busy is 0, the quotient reads 0x0101 and the product/remainder reads 0xFE01. The held multiplicand is 0xFF and the held dividend is 0xFFFF.
- R2: Writing address 0 stores the multiplicand. Writing address 1 starts a multiply with that byte as the multiplier. When busy falls, the product/remainder holds the 16-bit unsigned product.
- R3: A multiply keeps busy high for exactly 8 cycles after the cycle in which the start write is sampled.
- R4: Address 2 sets the dividend low byte and address 3 sets the dividend high byte. Each write leaves the other half unchanged.
- R5: Writing a non-zero divisor at address 4 keeps busy high for exactly 16 cycles. It then leaves the floor quotient in the quotient register and the remainder in the product/remainder register.
- R6: A divisor of zero never raises busy. The quotient becomes 0xFFFF and the product/remainder becomes the full dividend.
- R7: The read map is: address 0 quotient low byte, 1 quotient high byte, 2 product/remainder low byte, 3 product/remainder high byte. Every other read address returns 0. rd_data shows the selected byte one cycle after rd_addr is presented.
- R8: During a multiply, the product/remainder shows the running partial sum. After the first step it equals the multiplicand if multiplier bit 0 is 1, and 0 otherwise.
- R9: A start write during an operation restarts with the new operands, and busy is counted again from that write. A multiply started during a divide ends the divide and takes over the product/remainder. While idle and without a start write, both results hold their values.
- R10: The multiplicand and the dividend keep their values across operations, so a further multiplier or divisor write reuses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write register select |
| wr_data | input | W | Write data byte |
| rd_addr | input | AW | Read register select |
| rd_data | output | W | Registered read data |
| busy | output | 1 | An operation is in progress |

## Verification
The bench builds the block with its defaults, W=8 and AW=3, which gives 16-bit results. At that size the operands are small enough for a dense arithmetic grid. The multiply sweep covers multiplicands in steps of 15 against multipliers in steps of 7, and the divide sweep covers dividends spread over the full 16-bit range against every ninth divisor, including zero. Cycle-exact busy lengths, the first-step partial product, restarts in mid-operation and half-dividend writes are each driven on purpose.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  // write register codes
  localparam int WA_MCAND   = 0;
  localparam int WA_MPLIER  = 1;
  localparam int WA_DVD_LO  = 2;
  localparam int WA_DVD_HI  = 3;
  localparam int WA_DIVISOR = 4;
  // read register codes
  localparam int RA_QUO_LO  = 0;
  localparam int RA_QUO_HI  = 1;
  localparam int RA_PR_LO   = 2;
  localparam int RA_PR_HI   = 3;

  typedef enum logic {SRC_MUL = 1'b0, SRC_DIV = 1'b1} pr_src_e;
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           abort,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] acc_o,
  output logic           busy_o
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W + 1);
  localparam logic [PW-1:0] MAXOP   = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [PW-1:0] ACC_RST = MAXOP * MAXOP;

  logic [PW-1:0] acc_q, mcd_q;
  logic [W-1:0]  mpl_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= ACC_RST;
      mcd_q  <= '0;
      mpl_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (go) begin
      acc_q  <= '0;
      mcd_q  <= {{W{1'b0}}, op_a};
      mpl_q  <= op_b;
      cnt_q  <= CW'(W);
      busy_q <= 1'b1;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (mpl_q[0]) acc_q <= acc_q + mcd_q;
      mcd_q <= mcd_q << 1;
      mpl_q <= mpl_q >> 1;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign acc_o  = acc_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           abort,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic [2*W-1:0] quo_o,
  output logic [2*W-1:0] rem_o,
  output logic           busy_o
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(PW + 1);
  localparam logic [W-1:0]  BYTE_ONE = W'(1);
  localparam logic [PW-1:0] QUO_RST  = {BYTE_ONE, BYTE_ONE};

  logic [PW-1:0] rem_q, quo_q;
  logic [W-1:0]  dsr_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [W:0]    trial;
  logic          fits;
  logic [W-1:0]  diff;

  always_comb begin
    trial = {rem_q[W-1:0], quo_q[PW-1]};
    fits  = trial >= {1'b0, dsr_q};
    diff  = trial[W-1:0] - dsr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= QUO_RST;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (go) begin
      if (divisor == '0) begin
        quo_q  <= '1;
        rem_q  <= dividend;
        busy_q <= 1'b0;
      end else begin
        quo_q  <= dividend;
        rem_q  <= '0;
        dsr_q  <= divisor;
        cnt_q  <= CW'(PW);
        busy_q <= 1'b1;
      end
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      rem_q <= {{W{1'b0}}, (fits ? diff : trial[W-1:0])};
      quo_q <= {quo_q[PW-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          busy
);
  localparam int PW = 2 * W;

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] dvd_q;
  pr_src_e       src_q;
  logic          mul_go, div_go, mul_busy, div_busy;
  logic [PW-1:0] mul_acc, div_quo, div_rem;
  logic [PW-1:0] quo_w, prodrem_w;
  logic [W-1:0]  rd_q;

  assign mul_go = wr_en && (wr_addr == AW'(WA_MPLIER));
  assign div_go = wr_en && (wr_addr == AW'(WA_DIVISOR));

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '1;
      dvd_q   <= '1;
      src_q   <= SRC_MUL;
    end else begin
      if (wr_en && wr_addr == AW'(WA_MCAND))  mcand_q        <= wr_data;
      if (wr_en && wr_addr == AW'(WA_DVD_LO)) dvd_q[W-1:0]   <= wr_data;
      if (wr_en && wr_addr == AW'(WA_DVD_HI)) dvd_q[PW-1:W]  <= wr_data;
      if (mul_go) src_q <= SRC_MUL;
      if (div_go) src_q <= SRC_DIV;
    end
  end

  muldiv_mul #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .go(mul_go), .abort(div_go),
    .op_a(mcand_q), .op_b(wr_data), .acc_o(mul_acc), .busy_o(mul_busy)
  );

  muldiv_div #(.W(W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .abort(mul_go),
    .dividend(dvd_q), .divisor(wr_data),
    .quo_o(div_quo), .rem_o(div_rem), .busy_o(div_busy)
  );

  assign quo_w     = div_quo;
  assign prodrem_w = (src_q == SRC_DIV) ? div_rem : mul_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_addr)
        AW'(RA_QUO_LO): rd_q <= quo_w[W-1:0];
        AW'(RA_QUO_HI): rd_q <= quo_w[PW-1:W];
        AW'(RA_PR_LO):  rd_q <= prodrem_w[W-1:0];
        AW'(RA_PR_HI):  rd_q <= prodrem_w[PW-1:W];
        default:        rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign busy    = mul_busy | div_busy;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
  import muldiv_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [W-1:0]  wr_data,
  input logic          busy,
  input logic [2*W-1:0] quo,
  input logic [2*W-1:0] prodrem
);
  localparam int RW = $clog2(2 * W + 1) + 1;
  localparam logic [W-1:0]    ONE_B   = W'(1);
  localparam logic [2*W-1:0]  QUO_RST = {ONE_B, ONE_B};

  logic mstart, dstart;
  logic [RW-1:0] run_q;

  assign mstart = wr_en && (wr_addr == AW'(WA_MPLIER));
  assign dstart = wr_en && (wr_addr == AW'(WA_DIVISOR));

  always_ff @(posedge clk) begin
    if (rst || mstart || dstart) run_q <= '0;
    else if (busy)               run_q <= run_q + 1'b1;
    else                         run_q <= '0;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && quo == QUO_RST));

  a_r2_mul_busy: assert property (@(posedge clk) disable iff (rst)
    mstart |=> busy);

  a_r5_div_busy: assert property (@(posedge clk) disable iff (rst)
    (dstart && wr_data != '0) |=> busy);

  a_r5_div_len: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < RW'(2 * W)));

  a_r6_zero_idle: assert property (@(posedge clk) disable iff (rst)
    (dstart && wr_data == '0) |=> (!busy && quo == '1));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !mstart && !dstart) |=> ($stable(quo) && $stable(prodrem)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .quo(quo_w), .prodrem(prodrem_w)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0]  rd_data;
  logic          busy;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  muldiv_unit #(.W(W), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic rd16(input int lo, output int v);
    int l, h;
    rd(lo, l);
    rd(lo + 1, h);
    v = (h << 8) | l;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    chk("R1 busy", int'(busy), 0);
    rd16(0, v); chk("R1 quotient", v, 16'h0101);
    rd16(2, v); chk("R1 prodrem", v, 16'hFE01);
    // R1/R10 held multiplicand 0xFF: multiply by 2
    wr(1, 2); busy_len(n);
    rd16(2, v); chk("R1 mcand reset", v, 16'h01FE);
    // R1/R4 held dividend 0xFFFF, new low byte only
    wr(2, 8'h34); wr(4, 1); busy_len(n);
    rd16(0, v); chk("R4 low half", v, 16'hFF34);
    wr(3, 8'h12); wr(4, 1); busy_len(n);
    rd16(0, v); chk("R4 high half", v, 16'h1234);
    // R7 unused read addresses
    for (int a = 4; a < 8; a++) begin
      rd(a, v); chk("R7 unused addr", v, 0);
    end
    // R3 busy length
    wr(0, 8'h21); wr(1, 8'h37); busy_len(n);
    chk("R3 mul busy cycles", n, 8);
    // R10 multiplicand reused
    wr(1, 8'h05); busy_len(n);
    rd16(2, v); chk("R10 mcand reuse", v, 8'h21 * 5);
    // R8 intermediate value
    wr(0, 8'h5A);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(1); wr_data = 8'h03;
    @(negedge clk);
    wr_en = 1'b0; rd_addr = AW'(2);
    @(negedge clk);
    @(negedge clk);
    chk("R8 first step", int'(rd_data), 8'h5A);
    chk("R8 busy mid", int'(busy), 1);
    @(negedge clk);
    chk("R8 second step", int'(rd_data), 8'h0E);
    busy_len(n);
    rd16(2, v); chk("R8 final", v, 16'h010E);
    // R9 restart of multiply
    wr(0, 8'h10); wr(1, 8'hFF);
    @(negedge clk); @(negedge clk);
    wr(0, 8'h07); wr(1, 8'h09); busy_len(n);
    chk("R9 restart busy", n, 8);
    rd16(2, v); chk("R9 restart product", v, 16'h003F);
    // R9 multiply interrupts divide
    wr(2, 8'hCD); wr(3, 8'hAB); wr(4, 8'h07);
    repeat (4) @(negedge clk);
    wr(0, 8'h0B); wr(1, 8'h0D); busy_len(n);
    chk("R9 mul over div busy", n, 8);
    rd16(2, v); chk("R9 mul over div", v, 143);
    // R9 hold when idle
    repeat (5) @(negedge clk);
    rd16(2, v); chk("R9 hold", v, 143);
    // R5 busy length and edge divisors
    wr(4, 8'hFF); busy_len(n);
    chk("R5 div busy cycles", n, 16);
    rd16(0, v); chk("R5 quotient by 255", v, 16'hABCD / 255);
    rd16(2, v); chk("R5 remainder by 255", v, 16'hABCD % 255);
    // R6 zero divisor
    wr(4, 0); busy_len(n);
    chk("R6 no busy", n, 0);
    rd16(0, v); chk("R6 quotient", v, 16'hFFFF);
    rd16(2, v); chk("R6 remainder", v, 16'hABCD);
    // R2 multiply sweep
    for (int a = 0; a < 256; a += 15) begin
      wr(0, a);
      for (int b = 0; b < 256; b += 7) begin
        wr(1, b); busy_len(n);
        rd16(2, v); chk("R2 product", v, a * b);
      end
    end
    // R5/R6 divide sweep
    for (int k = 0; k < 17; k++) begin
      int dv;
      dv = (k == 16) ? 65535 : k * 4099;
      wr(2, dv & 8'hFF); wr(3, dv >> 8);
      for (int d = 0; d < 256; d += 9) begin
        wr(4, d); busy_len(n);
        chk(d == 0 ? "R6 busy" : "R5 busy", n, d == 0 ? 0 : 16);
        rd16(0, v); chk(d == 0 ? "R6 quo" : "R5 quo", v, d == 0 ? 65535 : dv / d);
        rd16(2, v); chk(d == 0 ? "R6 rem" : "R5 rem", v, d == 0 ? dv : dv % d);
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule